// File: doc/BRIEF.md
# Dual-Width Integer Execute Unit

This block is the integer execute stage of an accumulator-style processor whose native word is 12 bits. Each command arrives on a one-cycle `start` strobe with a 2-bit command kind. An integer command carries a 4-bit opcode, two operands and a bit that says whether the condition flags may change. The other kinds select the active integer width, or turn the stored carry or overflow flag into a skip. The block keeps a mode bit that sets the active width to 12 or 24 bits. Every integer operation works at that width. In 12-bit mode the upper operand bits are ignored and the result is returned zero-extended.

Add, subtract, the logic operations and increment-and-skip-if-zero finish in one cycle. Multiply and divide run iteratively, one bit per cycle, and hold `busy` until they finish. Every command ends with a one-cycle `done` pulse. A conditional jump is resolved without a clock from a 3-bit relation mask (less, equal, greater) and the stored relation flags. Carry and overflow are never visible to that jump; they are reached only through the two skip commands.

Top module: `iexu_core`

## Requirements
- R1: After reset the result is 0, the mode is 12-bit, equal is 1, and less, greater, carry, overflow, skip, done and busy are 0.
- R2: Command kinds are 00 integer operation, 01 set width (`set_wide` 1 selects 24 bits), 10 skip-if-carry, 11 skip-if-overflow. Integer opcodes are 0000 add, 0001 subtract, 0010 multiply, 0011 divide, 1000 AND, 1001 OR, 1010 XOR, 1011 increment-and-skip-if-zero. Any other opcode changes neither result nor flags. Every command other than multiply or divide raises `done` in the cycle after `start`.
- R3: Add and subtract wrap at the active width. Carry is the unsigned carry out; for subtract it is 1 when no borrow occurs. Overflow follows two's-complement rules.
- R4: AND, OR and XOR return the bitwise result, and when flags update they clear carry and overflow.
- R5: Increment-and-skip returns the operand plus one, wrapped, and raises skip when that value is zero. Its carry is the carry out, and its overflow is set when the operand was the largest positive value.
- R6: In 12-bit mode, operand bits 23..12 have no effect and result bits 23..12 are 0. The width changes only through the set-width command.
- R7: After a flag update exactly one of less, equal and greater is set, from a signed comparison of the result with zero at the active width.
- R8: Flags change only when an integer command with the update bit set completes; with the bit clear, the result changes but the flags hold.
- R9: `jump_taken` is 1 when any mask bit is set whose relation flag is set (bit 2 less, bit 1 equal, bit 0 greater). Mask 000 never jumps and 111 always jumps.
- R10: The skip-if-carry and skip-if-overflow commands raise skip equal to the stored flag and leave result and flags unchanged.
- R11: Multiply returns the low half of the signed product at the active width. It sets overflow when the product does not fit that width and clears carry. `busy` is high from the cycle after `start`, and `done` arrives W+2 cycles after `start` for width W.
- R12: Divide is signed and truncates toward zero, with the same timing as multiply, and clears carry. Division by zero returns all ones at the active width and sets overflow. The most negative value divided by -1 returns the most negative value with overflow set.
- R13: A `start` while `busy` is high is ignored.
- R14: `done` and `skip` are pulses; skip is 0 whenever done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, one cycle |
| cmd | input | 2 | Command kind |
| op | input | 4 | Integer opcode |
| cc_en | input | 1 | Allow flag update for this command |
| set_wide | input | 1 | New width for set-width command (1 = 24 bits) |
| opnd_a | input | 24 | First operand (incremented operand for skip-on-zero) |
| opnd_b | input | 24 | Second operand |
| jmp_mask | input | 3 | Relation mask: less, equal, greater |
| result | output | 24 | Last result, zero-extended in 12-bit mode |
| flag_lt | output | 1 | Result was negative |
| flag_eq | output | 1 | Result was zero |
| flag_gt | output | 1 | Result was positive |
| flag_cy | output | 1 | Carry flag |
| flag_ov | output | 1 | Overflow flag |
| skip | output | 1 | Skip request, valid with done |
| done | output | 1 | Command complete pulse |
| busy | output | 1 | Multiply or divide in progress |
| wide_mode | output | 1 | Active width is 24 bits |
| jump_taken | output | 1 | Branch decision from jmp_mask and flags |

## Verification
The checker assumes `rst_n` is low for at least one clock edge and that every input is a known 0 or 1 at each rising edge. It places no restriction on when `start` may come, because the block must absorb a strobe that arrives while busy. The stimulus changes inputs only on falling edges and holds reset across several edges. It issues one deliberate strobe during a multiply; every other command waits for the previous `done`. Mode changes happen only between commands, never while a long operation is in flight.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

    parameter int unsigned NLEN = 12;              // narrow integer width
    parameter int unsigned XLEN = 24;              // wide integer width
    localparam int unsigned PLEN = 2 * XLEN;       // full product width
    localparam int unsigned CW   = $clog2(XLEN + 1);

    typedef logic [XLEN-1:0] word_t;

    localparam logic [1:0] CMD_INT  = 2'd0;
    localparam logic [1:0] CMD_SETW = 2'd1;
    localparam logic [1:0] CMD_SKC  = 2'd2;
    localparam logic [1:0] CMD_SKV  = 2'd3;

    localparam logic [3:0] OP_ADD = 4'h0;
    localparam logic [3:0] OP_SUB = 4'h1;
    localparam logic [3:0] OP_MUL = 4'h2;
    localparam logic [3:0] OP_DIV = 4'h3;
    localparam logic [3:0] OP_AND = 4'h8;
    localparam logic [3:0] OP_OR  = 4'h9;
    localparam logic [3:0] OP_XOR = 4'hA;
    localparam logic [3:0] OP_ISZ = 4'hB;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } rel_t;

    typedef struct packed {
        word_t res;
        logic  cy;
        logic  ov;
        logic  skip;
        logic  hit;
    } alu_out_t;

    function automatic word_t wmask(input logic wide);
        return wide ? {XLEN{1'b1}} : {{(XLEN-NLEN){1'b0}}, {NLEN{1'b1}}};
    endfunction

    function automatic logic wsign(input word_t v, input logic wide);
        return wide ? v[XLEN-1] : v[NLEN-1];
    endfunction

    function automatic rel_t relate(input word_t v, input logic wide);
        rel_t r;
        logic z;
        logic s;
        z    = ((v & wmask(wide)) == '0);
        s    = wsign(v, wide);
        r.lt = s;
        r.eq = z;
        r.gt = !s && !z;
        return r;
    endfunction

    // signed value held in f fits the active width
    function automatic logic fits(input logic [PLEN-1:0] f, input logic wide);
        if (wide)
            return f[PLEN-1:XLEN-1] == {(PLEN-XLEN+1){f[XLEN-1]}};
        else
            return f[PLEN-1:NLEN-1] == {(PLEN-NLEN+1){f[NLEN-1]}};
    endfunction

endpackage

// File: rtl/iexu_alu.sv
module iexu_alu
    import iexu_pkg::*;
(
    input  logic       wide,
    input  logic [3:0] op,
    input  word_t      a,
    input  word_t      b,
    output alu_out_t   o
);

    word_t        mask;
    word_t        bx;
    logic         cin;
    logic [XLEN:0] sum;
    word_t        sres;
    logic         scy;
    logic         sov;

    assign mask = wmask(wide);

    // shared adder: add, subtract (a + ~b + 1), increment (a + 0 + 1)
    always_comb begin
        bx  = b;
        cin = 1'b0;
        if (op == OP_SUB) begin
            bx  = ~b & mask;
            cin = 1'b1;
        end else if (op == OP_ISZ) begin
            bx  = '0;
            cin = 1'b1;
        end
        sum  = {1'b0, a} + {1'b0, bx} + {{XLEN{1'b0}}, cin};
        sres = sum[XLEN-1:0] & mask;
        scy  = wide ? sum[XLEN] : sum[NLEN];
        sov  = (wsign(a, wide) == wsign(bx, wide)) && (wsign(sres, wide) != wsign(a, wide));
    end

    always_comb begin
        o = '0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                o.res = sres;
                o.cy  = scy;
                o.ov  = sov;
                o.hit = 1'b1;
            end
            OP_ISZ: begin
                o.res  = sres;
                o.cy   = scy;
                o.ov   = sov;
                o.skip = (sres == '0);
                o.hit  = 1'b1;
            end
            OP_AND: begin
                o.res = a & b;
                o.hit = 1'b1;
            end
            OP_OR: begin
                o.res = a | b;
                o.hit = 1'b1;
            end
            OP_XOR: begin
                o.res = a ^ b;
                o.hit = 1'b1;
            end
            default: o = '0;
        endcase
    end

endmodule

// File: rtl/iexu_muldiv.sv
module iexu_muldiv
    import iexu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  go,
    input  logic  is_div,
    input  logic  wide,
    input  word_t a,
    input  word_t b,
    output logic  fin,
    output word_t res,
    output logic  ovf
);

    typedef struct packed {
        logic            run;
        logic            div;
        logic            wide;
        logic            neg;
        logic            dz;
        logic [CW-1:0]   cnt;
        logic [PLEN-1:0] acc;
        logic [PLEN-1:0] mcand;
        word_t           mplr;
        word_t           rem;
        word_t           dvd;
        word_t           dsr;
        word_t           quo;
    } md_st_t;

    md_st_t q, d;

    word_t           ma;
    word_t           mb;
    logic [PLEN-1:0] full;
    logic [PLEN-1:0] sfull;
    logic [XLEN:0]   trial;
    logic            qbit;

    assign ma = wsign(a, wide) ? ((~a + 1'b1) & wmask(wide)) : a;
    assign mb = wsign(b, wide) ? ((~b + 1'b1) & wmask(wide)) : b;

    assign full  = q.div ? {{XLEN{1'b0}}, q.quo} : q.acc;
    assign sfull = q.neg ? (~full + 1'b1) : full;
    assign fin   = q.run && (q.cnt == '0);
    assign res   = q.dz ? wmask(q.wide) : (sfull[XLEN-1:0] & wmask(q.wide));
    assign ovf   = q.dz || !fits(sfull, q.wide);

    assign trial = {q.rem, q.dvd[XLEN-1]};
    assign qbit  = (trial >= {1'b0, q.dsr});

    always_comb begin
        d = q;
        if (fin) begin
            d.run = 1'b0;
        end else if (q.run) begin
            d.cnt = q.cnt - 1'b1;
            if (q.div) begin
                d.rem = qbit ? word_t'(trial - {1'b0, q.dsr}) : word_t'(trial);
                d.dvd = {q.dvd[XLEN-2:0], 1'b0};
                d.quo = {q.quo[XLEN-2:0], qbit};
            end else begin
                if (q.mplr[0])
                    d.acc = q.acc + q.mcand;
                d.mcand = {q.mcand[PLEN-2:0], 1'b0};
                d.mplr  = {1'b0, q.mplr[XLEN-1:1]};
            end
        end else if (go) begin
            d.run   = 1'b1;
            d.div   = is_div;
            d.wide  = wide;
            d.neg   = wsign(a, wide) ^ wsign(b, wide);
            d.dz    = is_div && (b == '0);
            d.cnt   = wide ? CW'(XLEN) : CW'(NLEN);
            d.acc   = '0;
            d.mcand = {{(PLEN-XLEN){1'b0}}, ma};
            d.mplr  = mb;
            d.rem   = '0;
            d.dvd   = wide ? ma : (ma << (XLEN - NLEN));
            d.dsr   = mb;
            d.quo   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/iexu_core.sv
module iexu_core
    import iexu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  cmd,
    input  logic [3:0]  op,
    input  logic        cc_en,
    input  logic        set_wide,
    input  logic [23:0] opnd_a,
    input  logic [23:0] opnd_b,
    input  logic [2:0]  jmp_mask,
    output logic [23:0] result,
    output logic        flag_lt,
    output logic        flag_eq,
    output logic        flag_gt,
    output logic        flag_cy,
    output logic        flag_ov,
    output logic        skip,
    output logic        done,
    output logic        busy,
    output logic        wide_mode,
    output logic        jump_taken
);

    typedef struct packed {
        word_t res;
        logic  lt;
        logic  eq;
        logic  gt;
        logic  cy;
        logic  ov;
        logic  wide;
        logic  skip;
        logic  done;
        logic  busy;
        logic  cc_pend;
    } core_st_t;

    localparam core_st_t ST_RST = '{res: '0, lt: 1'b0, eq: 1'b1, gt: 1'b0,
                                    cy: 1'b0, ov: 1'b0, wide: 1'b0, skip: 1'b0,
                                    done: 1'b0, busy: 1'b0, cc_pend: 1'b0};

    core_st_t q, d;

    word_t    a_m;
    word_t    b_m;
    alu_out_t alu_o;
    logic     md_go;
    logic     md_fin;
    word_t    md_res;
    logic     md_ovf;
    rel_t     rel_alu;
    rel_t     rel_md;
    logic     is_long;

    assign a_m = opnd_a & wmask(q.wide);
    assign b_m = opnd_b & wmask(q.wide);

    iexu_alu u_alu (
        .wide (q.wide),
        .op   (op),
        .a    (a_m),
        .b    (b_m),
        .o    (alu_o)
    );

    iexu_muldiv u_md (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (md_go),
        .is_div (op == OP_DIV),
        .wide   (q.wide),
        .a      (a_m),
        .b      (b_m),
        .fin    (md_fin),
        .res    (md_res),
        .ovf    (md_ovf)
    );

    assign rel_alu = relate(alu_o.res, q.wide);
    assign rel_md  = relate(md_res, q.wide);
    assign is_long = (op == OP_MUL) || (op == OP_DIV);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.skip = 1'b0;
        md_go  = 1'b0;
        if (q.busy) begin
            if (md_fin) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.res  = md_res;
                if (q.cc_pend) begin
                    d.lt = rel_md.lt;
                    d.eq = rel_md.eq;
                    d.gt = rel_md.gt;
                    d.cy = 1'b0;
                    d.ov = md_ovf;
                end
            end
        end else if (start) begin
            d.done = 1'b1;
            unique case (cmd)
                CMD_INT: begin
                    if (is_long) begin
                        md_go     = 1'b1;
                        d.busy    = 1'b1;
                        d.done    = 1'b0;
                        d.cc_pend = cc_en;
                    end else if (alu_o.hit) begin
                        d.res  = alu_o.res;
                        d.skip = alu_o.skip;
                        if (cc_en) begin
                            d.lt = rel_alu.lt;
                            d.eq = rel_alu.eq;
                            d.gt = rel_alu.gt;
                            d.cy = alu_o.cy;
                            d.ov = alu_o.ov;
                        end
                    end
                end
                CMD_SETW: d.wide = set_wide;
                CMD_SKC:  d.skip = q.cy;
                default:  d.skip = q.ov;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= ST_RST;
        else
            q <= d;
    end

    assign result     = q.res;
    assign flag_lt    = q.lt;
    assign flag_eq    = q.eq;
    assign flag_gt    = q.gt;
    assign flag_cy    = q.cy;
    assign flag_ov    = q.ov;
    assign skip       = q.skip;
    assign done       = q.done;
    assign busy       = q.busy;
    assign wide_mode  = q.wide;
    assign jump_taken = |(jmp_mask & {q.lt, q.eq, q.gt});

endmodule

// File: rtl/iexu_core_chk.sv
module iexu_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [23:0] result,
    input logic        flag_lt,
    input logic        flag_eq,
    input logic        flag_gt,
    input logic        flag_cy,
    input logic        flag_ov,
    input logic        skip,
    input logic        done,
    input logic        busy,
    input logic        wide_mode,
    input logic [2:0]  jmp_mask,
    input logic        jump_taken
);

    assert_rel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({flag_lt, flag_eq, flag_gt}));

    assert_flags_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({flag_lt, flag_eq, flag_gt, flag_cy, flag_ov}));

    assert_skip_gated_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !skip);

    assert_busy_no_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    assert_busy_ends_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_jump_never_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_mask == 3'b000) |-> !jump_taken);

    assert_jump_always_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_mask == 3'b111) |-> jump_taken);

    assert_narrow_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !wide_mode) |-> (result[23:12] == 12'h000));

endmodule

bind iexu_core iexu_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .result     (result),
    .flag_lt    (flag_lt),
    .flag_eq    (flag_eq),
    .flag_gt    (flag_gt),
    .flag_cy    (flag_cy),
    .flag_ov    (flag_ov),
    .skip       (skip),
    .done       (done),
    .busy       (busy),
    .wide_mode  (wide_mode),
    .jmp_mask   (jmp_mask),
    .jump_taken (jump_taken)
);

// File: tb/tb_iexu_core.sv
module tb_iexu_core;
    import iexu_pkg::*;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cmd = '0;
    logic [3:0]  op = '0;
    logic        cc_en = 1'b0;
    logic        set_wide = 1'b0;
    logic [23:0] opnd_a = '0;
    logic [23:0] opnd_b = '0;
    logic [2:0]  jmp_mask = '0;
    logic [23:0] result;
    logic        flag_lt, flag_eq, flag_gt, flag_cy, flag_ov;
    logic        skip, done, busy, wide_mode, jump_taken;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    iexu_core dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .op(op),
        .cc_en(cc_en), .set_wide(set_wide), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .jmp_mask(jmp_mask), .result(result), .flag_lt(flag_lt),
        .flag_eq(flag_eq), .flag_gt(flag_gt), .flag_cy(flag_cy),
        .flag_ov(flag_ov), .skip(skip), .done(done), .busy(busy),
        .wide_mode(wide_mode), .jump_taken(jump_taken)
    );

    task automatic chk(input string tag, input string what, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
        end
    endtask

    task automatic do_cmd(input logic [1:0] k, input logic [3:0] o, input logic [23:0] a,
                          input logic [23:0] b, input bit c, input bit sw, output int lat);
        @(negedge clk);
        start = 1'b1; cmd = k; op = o; opnd_a = a; opnd_b = b; cc_en = c; set_wide = sw;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic longint sv(input longint x, input longint w);
        return (x >= (64'sd1 <<< (w - 1))) ? x - (64'sd1 <<< w) : x;
    endfunction

    function automatic bit in_rng(input longint v, input longint w);
        return (v >= -(64'sd1 <<< (w - 1))) && (v <= (64'sd1 <<< (w - 1)) - 1);
    endfunction

    function automatic void model(input logic [3:0] o, input bit wide, input logic [23:0] a,
                                  input logic [23:0] b, output logic [23:0] r,
                                  output bit cy, output bit ov, output bit sk);
        longint w, m, am, bm, sa, sb, t;
        w  = wide ? 24 : 12;
        m  = (64'sd1 <<< w) - 1;
        am = longint'(a) & m;
        bm = longint'(b) & m;
        sa = sv(am, w);
        sb = sv(bm, w);
        cy = 0; ov = 0; sk = 0; t = 0;
        case (o)
            OP_ADD: begin t = am + bm; cy = ((t >>> w) & 1) != 0; ov = !in_rng(sa + sb, w); end
            OP_SUB: begin t = am - bm; cy = (am >= bm); ov = !in_rng(sa - sb, w); end
            OP_MUL: begin t = sa * sb; ov = !in_rng(t, w); end
            OP_DIV: begin
                if (bm == 0) begin t = m; ov = 1; end
                else begin t = sa / sb; ov = !in_rng(t, w); end
            end
            OP_AND: t = am & bm;
            OP_OR:  t = am | bm;
            OP_XOR: t = am ^ bm;
            OP_ISZ: begin t = am + 1; cy = ((t & m) == 0); ov = (am == (64'sd1 <<< (w - 1)) - 1); sk = ((t & m) == 0); end
            default: t = 0;
        endcase
        r = 24'(t & m);
    endfunction

    function automatic logic [2:0] rel_of(input logic [23:0] r, input bit wide);
        longint w;
        longint s;
        w = wide ? 24 : 12;
        s = sv(longint'(r), w);
        return {s < 0, s == 0, s > 0};
    endfunction

    task automatic check_op(input string tag, input logic [3:0] o, input logic [23:0] a, input logic [23:0] b);
        int lat;
        logic [23:0] er;
        bit ecy, eov, esk;
        bit w;
        w = wide_mode;
        model(o, w, a, b, er, ecy, eov, esk);
        do_cmd(CMD_INT, o, a, b, 1'b1, 1'b0, lat);
        chk(tag, "result", result, er);
        chk(tag, "carry", flag_cy, ecy);
        chk(tag, "overflow", flag_ov, eov);
        chk(tag, "rel", {flag_lt, flag_eq, flag_gt}, rel_of(er, w));
        if (o != OP_MUL && o != OP_DIV) begin
            chk(tag, "skip", skip, esk);
            chk("R2", "latency", lat, 1);
        end else begin
            chk(tag, "latency", lat, w ? 26 : 14);
        end
    endtask

    task automatic t_reset();
        chk("R1", "result", result, 0);
        chk("R1", "flags", {flag_lt, flag_eq, flag_gt, flag_cy, flag_ov}, 5'b01000);
        chk("R1", "ctl", {skip, done, busy, wide_mode}, 0);
        jmp_mask = 3'b111; #1;
        chk("R9", "always jump at reset", jump_taken, 1);
        jmp_mask = 3'b101; #1;
        chk("R9", "no match at reset", jump_taken, 0);
        jmp_mask = 3'b000;
    endtask

    task automatic t_arith();
        check_op("R3", OP_ADD, 24'h7FF, 24'h001);
        check_op("R3", OP_ADD, 24'hFFF, 24'h001);
        check_op("R3", OP_SUB, 24'h005, 24'h007);
        check_op("R3", OP_SUB, 24'h007, 24'h005);
        check_op("R3", OP_SUB, 24'h800, 24'h001);
        check_op("R7", OP_SUB, 24'h123, 24'h123);
    endtask

    task automatic t_logic();
        check_op("R3", OP_ADD, 24'hFFF, 24'h001);
        check_op("R4", OP_AND, 24'hF0F, 24'h3C3);
        check_op("R4", OP_OR,  24'h900, 24'h011);
        check_op("R4", OP_XOR, 24'h5A5, 24'h5A5);
    endtask

    task automatic t_isz();
        check_op("R5", OP_ISZ, 24'hFFF, 24'h0);
        @(negedge clk);
        chk("R14", "done pulse", done, 0);
        chk("R14", "skip pulse", skip, 0);
        check_op("R5", OP_ISZ, 24'h7FF, 24'h0);
        check_op("R5", OP_ISZ, 24'h005, 24'h0);
    endtask

    task automatic t_ccoff_jump();
        int lat;
        check_op("R7", OP_SUB, 24'h005, 24'h007);
        do_cmd(CMD_INT, OP_ADD, 24'hFFF, 24'h001, 1'b0, 1'b0, lat);
        chk("R8", "result updates", result, 0);
        chk("R8", "flags hold", {flag_lt, flag_eq, flag_gt, flag_cy, flag_ov}, 5'b10000);
        for (int m = 0; m < 8; m++) begin
            jmp_mask = 3'(m); #1;
            chk("R9", "jump on less", jump_taken, (m >> 2) & 1);
        end
        check_op("R7", OP_XOR, 24'h00F, 24'h00F);
        for (int m = 0; m < 8; m++) begin
            jmp_mask = 3'(m); #1;
            chk("R9", "jump on equal", jump_taken, (m >> 1) & 1);
        end
        jmp_mask = 3'b000;
    endtask

    task automatic t_unused();
        int lat;
        check_op("R3", OP_SUB, 24'h007, 24'h005);
        do_cmd(CMD_INT, 4'h4, 24'h111, 24'h222, 1'b1, 1'b0, lat);
        chk("R2", "unused opcode done", lat, 1);
        chk("R2", "unused opcode result", result, 24'h002);
        chk("R2", "unused opcode flags", {flag_lt, flag_eq, flag_gt, flag_cy, flag_ov}, 5'b00110);
    endtask

    task automatic t_skip();
        int lat;
        check_op("R3", OP_ADD, 24'hFFF, 24'h001);
        do_cmd(CMD_SKC, 4'h0, 24'h0, 24'h0, 1'b1, 1'b0, lat);
        chk("R10", "skip carry set", skip, 1);
        do_cmd(CMD_SKV, 4'h0, 24'h0, 24'h0, 1'b1, 1'b0, lat);
        chk("R10", "skip ovf clear", skip, 0);
        chk("R10", "result kept", result, 0);
        check_op("R3", OP_ADD, 24'h7FF, 24'h001);
        do_cmd(CMD_SKC, 4'h0, 24'h0, 24'h0, 1'b1, 1'b0, lat);
        chk("R10", "skip carry clear", skip, 0);
        do_cmd(CMD_SKV, 4'h0, 24'h0, 24'h0, 1'b1, 1'b0, lat);
        chk("R10", "skip ovf set", skip, 1);
        chk("R10", "flags kept", {flag_lt, flag_eq, flag_gt, flag_cy, flag_ov}, 5'b10001);
        chk("R10", "result kept", result, 24'h800);
    endtask

    task automatic t_width();
        int lat;
        check_op("R6", OP_ADD, 24'h5A5001, 24'hF00002);
        chk("R6", "upper zero", result[23:12], 0);
        check_op("R6", OP_MUL, 24'hABC7FF, 24'h123002);
        chk("R6", "mul upper zero", result[23:12], 0);
        do_cmd(CMD_SETW, 4'h0, 24'h0, 24'h0, 1'b0, 1'b1, lat);
        chk("R6", "wide selected", wide_mode, 1);
        chk("R2", "setw latency", lat, 1);
        check_op("R6", OP_ADD, 24'h7FFFFF, 24'h000001);
        check_op("R3", OP_SUB, 24'h000000, 24'h000001);
        check_op("R5", OP_ISZ, 24'hFFFFFF, 24'h0);
    endtask

    task automatic t_muldiv_wide();
        check_op("R11", OP_MUL, 24'd1000, 24'd1000);
        check_op("R11", OP_MUL, 24'd5000, 24'd5000);
        check_op("R11", OP_MUL, 24'hFFFFFD, 24'd7);
        check_op("R12", OP_DIV, 24'd1000000, 24'd7);
        check_op("R12", OP_DIV, 24'h800000, 24'hFFFFFF);
        check_op("R12", OP_DIV, 24'd55, 24'd0);
    endtask

    task automatic t_muldiv_narrow();
        int lat;
        do_cmd(CMD_SETW, 4'h0, 24'h0, 24'h0, 1'b0, 1'b0, lat);
        chk("R6", "narrow selected", wide_mode, 0);
        check_op("R11", OP_MUL, 24'd12, 24'hFFD);
        check_op("R11", OP_MUL, 24'd100, 24'd50);
        check_op("R11", OP_MUL, 24'h800, 24'd1);
        check_op("R11", OP_MUL, 24'd0, 24'd77);
        check_op("R12", OP_DIV, 24'd7, 24'hFFE);
        check_op("R12", OP_DIV, 24'hFF9, 24'd2);
        check_op("R12", OP_DIV, 24'd100, 24'd0);
        check_op("R12", OP_DIV, 24'h800, 24'hFFF);
        check_op("R12", OP_DIV, 24'd0, 24'd5);
    endtask

    task automatic t_busy();
        int lat;
        logic [23:0] er;
        bit ecy, eov, esk;
        model(OP_MUL, 1'b0, 24'd9, 24'd11, er, ecy, eov, esk);
        @(negedge clk);
        start = 1'b1; cmd = CMD_INT; op = OP_MUL; opnd_a = 24'd9; opnd_b = 24'd11; cc_en = 1'b1;
        @(negedge clk);
        chk("R11", "busy raised", busy, 1);
        op = OP_SUB; opnd_a = 24'd1; opnd_b = 24'd2;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        lat = 3;
        chk("R13", "no early done", done, 0);
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk("R13", "latency kept", lat, 14);
        chk("R13", "mul result kept", result, er);
        chk("R13", "flags from mul", {flag_lt, flag_eq, flag_gt, flag_cy, flag_ov}, 5'b00100);
        @(negedge clk);
        chk("R13", "single done", done, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        total++;
        $display("FAIL R14 watchdog expired got=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arith();
        t_logic();
        t_isz();
        t_ccoff_jump();
        t_unused();
        t_skip();
        t_width();
        t_muldiv_wide();
        t_muldiv_narrow();
        t_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule